// File: doc/BRIEF.md
# Input-Change Wake Detector

This block lets a powered-down device notice that any of a wide set of input lines has moved. Just before the device goes to sleep, a clocked strobe copies the present value of the monitored lines into a snapshot register. From then on, a purely combinational comparison of the live lines against that snapshot drives a change flag. The flag can rise while the clock is stopped, so external power logic can use it to restart the clock. Once the clock runs again, a two-stage synchronizer turns the flag into a wake request that is safe to use in the clock domain.

The comparison tests for a difference against the stored copy, bit by bit. It does not OR the lines together, so an idle bundle that sits mostly high raises no flag. The comparison is split into fixed-size groups whose partial results are then combined, which keeps the depth of each reduction tree bounded.

A synchronous active-low reset clears the synchronizer. While reset is held, the snapshot tracks the inputs, so the flag is low as soon as the block leaves reset.

Top module: `wake_detector`

## Requirements
- R1: The width of the monitored vector is the parameter `LINES`, with a default of 66.
- R2: `change_async` is 1 exactly when `mon_lines` differs from the snapshot in at least one bit, in either direction. It is 0 when all bits are equal, including after a changed line returns to its snapshot value.
- R3: `change_async` follows `mon_lines` with no clock edge, so it rises while the clock is stopped.
- R4: A rising clock edge with `rst_n`=1 and `sleep_req`=1 copies `mon_lines` into the snapshot. With the lines unchanged, `change_async` is 0 after that edge.
- R5: While `sleep_req` is 0 and `rst_n` is 1, the snapshot holds its value, and changes on the lines leave it untouched.
- R6: At every rising edge with `rst_n`=0, the snapshot loads `mon_lines`. After reset, with the lines unchanged, neither output is raised.
- R7: `wake_req` equals the value of `change_async` sampled two rising edges earlier, through two flip-flops, provided `rst_n` was 1 at both edges.
- R8: With all lines idle at 1, a single line falling to 0 raises `change_async`. A plain OR of the lines would miss this.
- R9: A rising edge with `rst_n`=0 clears both synchronizer stages, so `wake_req` is 0 during reset and at the first edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; runs only while the device is awake |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_req | input | 1 | Strobe sampled on the clock; captures the snapshot before sleep |
| mon_lines | input | LINES | Monitored input lines |
| change_async | output | 1 | Combinational flag: lines differ from the snapshot |
| wake_req | output | 1 | Change flag after the two-flop synchronizer |

## Verification
On every cycle, the in-RTL assertions check the following:
- the grouped comparator agrees with a full-width inequality;
- the snapshot loads on a strobe or in reset, and holds otherwise;
- each synchronizer stage copies the stage before it;
- the request stays low after reset.

Only the bench scenarios can show the behaviour with the clock stopped:
- the flag rises with no edge at all;
- the request appears exactly two edges after the clock restarts;
- an all-ones idle bundle with one falling line is still caught.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int unsigned DEF_LINES = 66;
    localparam int unsigned DEF_GROUP = 16;

    typedef struct packed {
        logic first;
        logic second;
    } sync_pair_t;

    function automatic int unsigned group_count(input int unsigned lines, input int unsigned grp);
        return (lines + grp - 1) / grp;
    endfunction

    function automatic int unsigned group_top(input int unsigned idx, input int unsigned lines,
                                              input int unsigned grp);
        int unsigned top;
        top = (idx + 1) * grp;
        if (top > lines) top = lines;
        return top - 1;
    endfunction

endpackage

// File: rtl/wake_snapshot.sv
module wake_snapshot #(
    parameter int unsigned LINES = wake_pkg::DEF_LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LINES-1:0] lines_in,
    output logic [LINES-1:0] snap
);

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            snap <= lines_in;
        end
    end

    // R4: a strobe stores the lines seen at that edge
    assert_snap_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (snap == $past(lines_in)));

    // R5: with no strobe the stored copy is stable
    assert_snap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(snap));

endmodule

// File: rtl/wake_compare.sv
module wake_compare #(
    parameter int unsigned LINES = wake_pkg::DEF_LINES,
    parameter int unsigned GROUP = wake_pkg::DEF_GROUP
) (
    input  logic [LINES-1:0] lines_in,
    input  logic [LINES-1:0] snap,
    output logic             differ
);

    localparam int unsigned NGRP = wake_pkg::group_count(LINES, GROUP);

    logic [NGRP-1:0] grp_diff;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int unsigned LO = g * GROUP;
        localparam int unsigned HI = wake_pkg::group_top(g, LINES, GROUP);
        assign grp_diff[g] = |(lines_in[HI:LO] ^ snap[HI:LO]);
    end

    assign differ = |grp_diff;

    // R2: grouped reduction must match a full-width inequality
    always_comb begin
        if (!$isunknown({lines_in, snap})) begin
            assert_cmp_exact_R2: assert (differ == (lines_in != snap));
        end
    end

endmodule

// File: rtl/wake_sync.sv
module wake_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    import wake_pkg::*;

    sync_pair_t stage;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            stage.first  <= din;
            stage.second <= stage.first;
        end
    end

    assign dout = stage.second;

    // R7: each stage copies the previous one
    assert_sync_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stage.first == $past(din)));
    assert_sync_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dout == $past(stage.first)));

    // R9: request is low right after a reset edge
    assert_sync_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !dout);

endmodule

// File: rtl/wake_detector.sv
module wake_detector #(
    parameter int unsigned LINES = wake_pkg::DEF_LINES,
    parameter int unsigned GROUP = wake_pkg::DEF_GROUP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic [LINES-1:0] mon_lines,
    output logic             change_async,
    output logic             wake_req
);

    logic [LINES-1:0] snap;

    wake_snapshot #(.LINES(LINES)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sleep_req),
        .lines_in (mon_lines),
        .snap     (snap)
    );

    wake_compare #(.LINES(LINES), .GROUP(GROUP)) u_cmp (
        .lines_in (mon_lines),
        .snap     (snap),
        .differ   (change_async)
    );

    wake_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (change_async),
        .dout  (wake_req)
    );

    // R6: in reset the copy tracks the lines, so no flag after the edge
    assert_reset_track_R6: assert property (@(posedge clk)
        (!rst_n && !$isunknown(mon_lines)) |=> (snap == $past(mon_lines)));

endmodule

// File: tb/tb_wake_detector.sv
module tb_wake_detector;

    localparam int unsigned LINES = 66;   // R1 default width

    logic             clk = 1'b0;
    bit               clk_run = 1'b1;
    logic             rst_n;
    logic             sleep_req;
    logic [LINES-1:0] mon_lines;
    logic             change_async;
    logic             wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    wake_detector dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .mon_lines    (mon_lines),
        .change_async (change_async),
        .wake_req     (wake_req)
    );

    always begin
        #5;
        if (clk_run) clk = ~clk;
    end

    // behavioural reference
    logic [LINES-1:0] m_snap;
    bit               m_q[$];

    initial begin
        m_q = '{1'b0, 1'b0};
        m_snap = '0;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit nxt;
        nxt = rst_n ? (mon_lines != m_snap) : 1'b0;
        if (!rst_n) begin
            m_q = '{1'b0, 1'b0};
        end else begin
            void'(m_q.pop_front());
            m_q.push_back(nxt);
        end
        if (!rst_n || sleep_req) m_snap = mon_lines;
        #3;
        chk("R2 change vs model", change_async, (mon_lines != m_snap));
        chk("R7 wake vs model", wake_req, m_q[0]);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        sleep_req = 1'b0;
        mon_lines = '1;
        step(3);
        chk("R9 wake in reset", wake_req, 1'b0);
        chk("R6 change in reset", change_async, 1'b0);
        rst_n = 1'b1;
        step(4);
        chk("R6 no false wake", wake_req, 1'b0);
        chk("R6 no flag after reset", change_async, 1'b0);

        // R5: awake, line moves, copy must hold
        mon_lines[5] = 1'b0;
        #1 chk("R5 copy held, flag up", change_async, 1'b1);
        step(2);
        chk("R7 wake after two edges", wake_req, 1'b1);
        mon_lines[5] = 1'b1;
        #1 chk("R2 restored value clears", change_async, 1'b0);
        step(3);
        chk("R7 wake drops", wake_req, 1'b0);

        // R4: capture a pattern
        mon_lines = {2'b10, {16{4'hA}}};
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        chk("R4 flag low after capture", change_async, 1'b0);
        step(3);
        chk("R4 wake low after capture", wake_req, 1'b0);

        // R3/R8: stop clock, all-ones idle, one bit falls
        mon_lines = '1;
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        step(3);
        clk_run = 1'b0;
        #20;
        mon_lines[65] = 1'b0;
        #2;
        chk("R3 flag without clock", change_async, 1'b1);
        chk("R8 single fall in all-ones", change_async, 1'b1);
        chk("R3 wake waits for clock", wake_req, 1'b0);
        #30;
        clk_run = 1'b1;
        step(1);
        chk("R7 one edge not enough", wake_req, 1'b0);
        step(1);
        chk("R7 wake after restart", wake_req, 1'b1);

        // R2: varied patterns, both directions
        for (int i = 0; i < 20; i++) begin
            logic [LINES-1:0] pat;
            pat = {$urandom, $urandom, $urandom};
            mon_lines = pat;
            sleep_req = 1'b1;
            step(1);
            sleep_req = 1'b0;
            chk("R4 capture random", change_async, 1'b0);
            mon_lines[i*3] = ~pat[i*3];
            #1 chk("R2 one bit flipped", change_async, 1'b1);
            step(1);
            mon_lines = pat;
            #1 chk("R2 returned equal", change_async, 1'b0);
            step(2);
        end

        // R4: strobe held while lines move each cycle
        sleep_req = 1'b1;
        for (int i = 0; i < 8; i++) begin
            mon_lines = mon_lines ^ (66'd1 << (i * 8));
            step(1);
        end
        sleep_req = 1'b0;
        chk("R4 continuous capture", change_async, 1'b0);

        // R9: reset with pending change
        mon_lines[0] = ~mon_lines[0];
        step(2);
        chk("R7 pending wake", wake_req, 1'b1);
        rst_n = 1'b0;
        step(1);
        chk("R9 reset clears wake", wake_req, 1'b0);
        chk("R6 reset reloads copy", change_async, 1'b0);
        rst_n = 1'b1;
        step(3);
        chk("R6 quiet after reset", wake_req, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule